// File: doc/BRIEF.md
# Load/Store Translation Front-End Checker

This block sits between the load/store pipeline and the translation buffer. For each data request it decodes a packed 64-bit translation state word and picks the context and the translation kind (virtual or real). It can bypass translation for hypervisor accesses. It checks alignment and the unimplemented virtual address hole. When a lookup is needed it drives the buffer's combinational lookup port. It then applies the page permission checks in a fixed priority order.

The result of each request is one of two outcomes. The first is a physical address with an uncacheable flag. The second is a one-hot fault code, together with the tag-access value that the fault handler would latch. Requests enter on a valid/ready handshake. Each accepted request produces exactly one registered response, and that response is held until the consumer takes it. Buffer storage, exception vectoring and register-space accesses are handled by neighbouring blocks.

Top module: `dtc_top`

## Requirements
- R1: After reset, `rsp_valid` is low and `req_ready` is high.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its response appears with `rsp_valid` after that edge. Responses come out in acceptance order. A response and its fields stay unchanged while `rsp_ready` is low. `req_ready` is high exactly when no response is pending or the pending one is being taken.
- R3: The state word is decoded as follows:
  - bit 0: hypervisor;
  - bit 1: red state;
  - bit 2: privileged;
  - bit 3: 32-bit address mask;
  - bit 5: translation enable;
  - bits [15:8]: partition;
  - bits [18:16]: trap level;
  - bits [47:32]: primary context;
  - bits [63:48]: secondary context.
- R4: A hypervisor request in the implicit space bypasses every check. It returns ok, with `rsp_pa` equal to the low PA_W bits of the untruncated `req_va`, and with uncacheable low.
- R5: A request with any `req_va` bit set below 2^`req_size` bytes faults with `rsp_fault` bit 0 (misaligned). This check runs before every check except R4.
- R6: With the address mask set, the address used for all later steps has its upper 32 bits cleared. An address from HOLE_LO to HOLE_HI inclusive faults with bit 1 (out of range).
- R7: A hypervisor request in a non-implicit, non-real space that passes R5 and R6 is bypassed. `rsp_pa` is the low PA_W bits of the masked address.
- R8: Real translation is used when translation is disabled and neither hypervisor nor red state is set, or when `req_real` is high. The context is chosen as follows:
  - implicit space: primary when the trap level is 0, and 0 otherwise;
  - otherwise, by `req_ctxsel`: 0 selects primary, 1 selects secondary, 2 or 3 select 0.
- R9: A lookup miss faults with bit 2 when the translation is real and with bit 3 otherwise. It sets `rsp_tag_wr`, and `rsp_tag` = {va[63:13], ctx[12:0]}.
- R10: On a hit, the checks are taken in this priority:
  1. privileged page accessed with the privileged bit clear, bit 4;
  2. write to a non-writable page, bit 5;
  3. no-fault-only page accessed without `req_nofault`, bit 6;
  4. side-effect page accessed with `req_nofault`, bit 7.

  Each of these faults sets `rsp_tag_wr` with the R9 tag.
- R11: A hit that passes all checks returns ok. `rsp_pa` keeps the frame bits at and above `lk_shift` and takes the address bits below it. `rsp_uncache` equals the page's side-effect flag. On any fault, `rsp_pa` is 0. When `rsp_tag_wr` is low, `rsp_tag` is 0.
- R12: In every response, exactly one of `rsp_ok` and the bits of `rsp_fault` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_state | input | 64 | Packed translation state word |
| req_va | input | 64 | Virtual address |
| req_size | input | 2 | Log2 of access size in bytes |
| req_write | input | 1 | Store access |
| req_implicit | input | 1 | Implicit address space |
| req_real | input | 1 | Real address space requested |
| req_nofault | input | 1 | No-fault address space |
| req_ctxsel | input | 2 | Context select for explicit spaces |
| lk_en | output | 1 | Lookup issued this cycle |
| lk_va | output | 64 | Lookup address |
| lk_ctx | output | 16 | Lookup context |
| lk_part | output | 8 | Lookup partition |
| lk_real | output | 1 | Lookup is a real translation |
| lk_hit | input | 1 | Buffer hit |
| lk_pa | input | PA_W | Page frame address |
| lk_shift | input | 6 | Log2 of page size |
| lk_priv | input | 1 | Page is privileged |
| lk_writable | input | 1 | Page is writable |
| lk_nofault | input | 1 | Page only for no-fault spaces |
| lk_sideeff | input | 1 | Page has side effects |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_pa | output | PA_W | Physical address |
| rsp_uncache | output | 1 | Access is uncacheable |
| rsp_fault | output | 8 | One-hot fault code |
| rsp_tag_wr | output | 1 | Tag-access value must be latched |
| rsp_tag | output | 64 | Tag-access value |

## Verification
Two things can happen in the same cycle: a pending response is handed off, and a new request is accepted with its lookup. The bench sets `rsp_ready` at random, so back-to-back acceptance while draining happens often, alongside stalls that must hold the response fields. Each accepted request is queued with its expected outcome, computed from a separate model. Every handed-off response is compared in order against that queue. A cycle of stall is also compared against the cycle before it.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  localparam int VA_W      = 64;
  localparam int NFAULT    = 8;
  localparam int TAG_LOW_W = 13;

  // fault bit positions (priority order inside the hit checks matters)
  localparam int F_ALIGN   = 0;
  localparam int F_RANGE   = 1;
  localparam int F_RMISS   = 2;
  localparam int F_VMISS   = 3;
  localparam int F_PRIV    = 4;
  localparam int F_PROT    = 5;
  localparam int F_NFPAGE  = 6;
  localparam int F_SIDEEFF = 7;

  typedef enum logic [1:0] {
    CS_PRI = 2'd0,
    CS_SEC = 2'd1,
    CS_NUC = 2'd2,
    CS_RSV = 2'd3
  } ctxsel_e;

  typedef struct packed {
    logic [15:0] sec_ctx;
    logic [15:0] pri_ctx;
    logic [2:0]  tl;
    logic [7:0]  part;
    logic        xlate_en;
    logic        amask;
    logic        priv;
    logic        red;
    logic        hpriv;
  } dtc_state_t;

  function automatic logic dtc_misaligned(input logic [VA_W-1:0] va,
                                          input logic [1:0] size);
    logic [3:0] m;
    m = (4'd1 << size) - 4'd1;
    return |(va[2:0] & m[2:0]);
  endfunction

  function automatic logic [VA_W-1:0] dtc_compose(input logic [VA_W-1:0] frame,
                                                  input logic [VA_W-1:0] va,
                                                  input logic [5:0] shift);
    logic [VA_W-1:0] m;
    m = (64'd1 << shift) - 64'd1;
    return (frame & ~m) | (va & m);
  endfunction

  function automatic logic [VA_W-1:0] dtc_tag(input logic [VA_W-1:0] va,
                                              input logic [15:0] ctx);
    return {va[VA_W-1:TAG_LOW_W], ctx[TAG_LOW_W-1:0]};
  endfunction

endpackage

// File: rtl/dtc_state_decode.sv
module dtc_state_decode
  import dtc_pkg::*;
(
  input  logic [63:0] word,
  output dtc_state_t  st
);
  always_comb begin
    st.hpriv    = word[0];
    st.red      = word[1];
    st.priv     = word[2];
    st.amask    = word[3];
    st.xlate_en = word[5];
    st.part     = word[15:8];
    st.tl       = word[18:16];
    st.pri_ctx  = word[47:32];
    st.sec_ctx  = word[63:48];
  end
endmodule

// File: rtl/dtc_precheck.sv
module dtc_precheck
  import dtc_pkg::*;
#(
  parameter logic [63:0] HOLE_LO = 64'h0000_8000_0000_0000,
  parameter logic [63:0] HOLE_HI = 64'hFFFF_7FFF_FFFF_FFFF
)(
  input  dtc_state_t       st,
  input  logic [VA_W-1:0]  va,
  input  logic [1:0]       size,
  input  logic             implicit_sp,
  input  logic             real_sp,
  input  logic [1:0]       ctxsel,
  output logic [VA_W-1:0]  eff_va,
  output logic [15:0]      ctx,
  output logic             use_real,
  output logic             byp_now,
  output logic             byp_late,
  output logic             f_align,
  output logic             f_range,
  output logic             need_lookup,
  output logic [VA_W-1:0]  byp_va
);
  logic misal, in_hole, late_ok;

  always_comb begin
    eff_va   = st.amask ? {32'h0, va[31:0]} : va;
    misal    = dtc_misaligned(va, size);
    in_hole  = (eff_va >= HOLE_LO) && (eff_va <= HOLE_HI);
    byp_now  = st.hpriv && implicit_sp;
    f_align  = !byp_now && misal;
    f_range  = !byp_now && !misal && in_hole;
    late_ok  = st.hpriv && !implicit_sp && !real_sp;
    byp_late = late_ok && !f_align && !f_range;
    use_real = (!st.xlate_en && !st.hpriv && !st.red) || real_sp;
    need_lookup = !byp_now && !f_align && !f_range && !late_ok;
    byp_va   = byp_now ? va : eff_va;
    if (implicit_sp) begin
      ctx = (st.tl == 3'd0) ? st.pri_ctx : 16'h0;
    end else begin
      unique case (ctxsel_e'(ctxsel))
        CS_PRI:  ctx = st.pri_ctx;
        CS_SEC:  ctx = st.sec_ctx;
        default: ctx = 16'h0;
      endcase
    end
  end
endmodule

// File: rtl/dtc_perm_check.sv
module dtc_perm_check
  import dtc_pkg::*;
#(
  parameter int PA_W = 40
)(
  input  logic             hit,
  input  logic [PA_W-1:0]  frame,
  input  logic [5:0]       shift,
  input  logic             pg_priv,
  input  logic             pg_wr,
  input  logic             pg_nf,
  input  logic             pg_se,
  input  logic             acc_priv,
  input  logic             acc_write,
  input  logic             acc_nf_space,
  input  logic             acc_real,
  input  logic [VA_W-1:0]  va,
  input  logic [15:0]      ctx,
  output logic [NFAULT-1:0] fault,
  output logic             ok,
  output logic [PA_W-1:0]  pa,
  output logic             uncache,
  output logic             tag_wr,
  output logic [VA_W-1:0]  tag
);
  logic viol_priv, viol_prot, viol_nf, viol_se;
  logic [VA_W-1:0] pa64;

  assign viol_priv = pg_priv && !acc_priv;
  assign viol_prot = acc_write && !pg_wr;
  assign viol_nf   = pg_nf && !acc_nf_space;
  assign viol_se   = pg_se && acc_nf_space;
  assign pa64      = dtc_compose({{(VA_W-PA_W){1'b0}}, frame}, va, shift);

  always_comb begin
    fault   = '0;
    ok      = 1'b0;
    pa      = '0;
    uncache = 1'b0;
    if (!hit) begin
      if (acc_real) fault[F_RMISS] = 1'b1;
      else          fault[F_VMISS] = 1'b1;
    end else if (viol_priv) begin
      fault[F_PRIV] = 1'b1;
    end else if (viol_prot) begin
      fault[F_PROT] = 1'b1;
    end else if (viol_nf) begin
      fault[F_NFPAGE] = 1'b1;
    end else if (viol_se) begin
      fault[F_SIDEEFF] = 1'b1;
    end else begin
      ok      = 1'b1;
      pa      = pa64[PA_W-1:0];
      uncache = pg_se;
    end
    tag_wr = !ok;
    tag    = tag_wr ? dtc_tag(va, ctx) : '0;
  end
endmodule

// File: rtl/dtc_top.sv
module dtc_top
  import dtc_pkg::*;
#(
  parameter int          PA_W    = 40,
  parameter logic [63:0] HOLE_LO = 64'h0000_8000_0000_0000,
  parameter logic [63:0] HOLE_HI = 64'hFFFF_7FFF_FFFF_FFFF
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_state,
  input  logic [63:0]       req_va,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              req_implicit,
  input  logic              req_real,
  input  logic              req_nofault,
  input  logic [1:0]        req_ctxsel,
  output logic              lk_en,
  output logic [63:0]       lk_va,
  output logic [15:0]       lk_ctx,
  output logic [7:0]        lk_part,
  output logic              lk_real,
  input  logic              lk_hit,
  input  logic [PA_W-1:0]   lk_pa,
  input  logic [5:0]        lk_shift,
  input  logic              lk_priv,
  input  logic              lk_writable,
  input  logic              lk_nofault,
  input  logic              lk_sideeff,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_ok,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_uncache,
  output logic [NFAULT-1:0] rsp_fault,
  output logic              rsp_tag_wr,
  output logic [63:0]       rsp_tag
);
  dtc_state_t st;
  logic [VA_W-1:0] eff_va, byp_va;
  logic [15:0] ctx;
  logic use_real, byp_now, byp_late, f_align, f_range, need_lookup;
  logic accept;

  logic [NFAULT-1:0] pc_fault;
  logic pc_ok, pc_unc, pc_tag_wr;
  logic [PA_W-1:0] pc_pa;
  logic [VA_W-1:0] pc_tag;

  logic [NFAULT-1:0] n_fault;
  logic n_ok, n_unc, n_tag_wr;
  logic [PA_W-1:0] n_pa;
  logic [VA_W-1:0] n_tag;

  dtc_state_decode u_dec (.word(req_state), .st(st));

  dtc_precheck #(.HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI)) u_pre (
    .st(st), .va(req_va), .size(req_size), .implicit_sp(req_implicit),
    .real_sp(req_real), .ctxsel(req_ctxsel), .eff_va(eff_va), .ctx(ctx),
    .use_real(use_real), .byp_now(byp_now), .byp_late(byp_late),
    .f_align(f_align), .f_range(f_range), .need_lookup(need_lookup),
    .byp_va(byp_va)
  );

  dtc_perm_check #(.PA_W(PA_W)) u_perm (
    .hit(lk_hit), .frame(lk_pa), .shift(lk_shift), .pg_priv(lk_priv),
    .pg_wr(lk_writable), .pg_nf(lk_nofault), .pg_se(lk_sideeff),
    .acc_priv(st.priv), .acc_write(req_write), .acc_nf_space(req_nofault),
    .acc_real(use_real), .va(eff_va), .ctx(ctx), .fault(pc_fault),
    .ok(pc_ok), .pa(pc_pa), .uncache(pc_unc), .tag_wr(pc_tag_wr),
    .tag(pc_tag)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign lk_en     = accept && need_lookup;
  assign lk_va     = eff_va;
  assign lk_ctx    = ctx;
  assign lk_part   = st.part;
  assign lk_real   = use_real;

  always_comb begin
    n_fault  = '0;
    n_ok     = 1'b0;
    n_pa     = '0;
    n_unc    = 1'b0;
    n_tag_wr = 1'b0;
    n_tag    = '0;
    if (f_align) begin
      n_fault[F_ALIGN] = 1'b1;
    end else if (f_range) begin
      n_fault[F_RANGE] = 1'b1;
    end else if (byp_now || byp_late) begin
      n_ok = 1'b1;
      n_pa = byp_va[PA_W-1:0];
    end else begin
      n_fault  = pc_fault;
      n_ok     = pc_ok;
      n_pa     = pc_pa;
      n_unc    = pc_unc;
      n_tag_wr = pc_tag_wr;
      n_tag    = pc_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_ok      <= 1'b0;
      rsp_pa      <= '0;
      rsp_uncache <= 1'b0;
      rsp_fault   <= '0;
      rsp_tag_wr  <= 1'b0;
      rsp_tag     <= '0;
    end else if (accept) begin
      rsp_valid   <= 1'b1;
      rsp_ok      <= n_ok;
      rsp_pa      <= n_pa;
      rsp_uncache <= n_unc;
      rsp_fault   <= n_fault;
      rsp_tag_wr  <= n_tag_wr;
      rsp_tag     <= n_tag;
    end else if (rsp_ready) begin
      rsp_valid   <= 1'b0;
    end
  end

  // R12
  onehot_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_ok, rsp_fault}) == 1);

  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_fault)
      && $stable(rsp_pa) && $stable(rsp_tag) && $stable(rsp_ok));

  // R11
  uncache_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_uncache |-> rsp_ok);

  // R9
  tag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_tag_wr |-> (rsp_fault[NFAULT-1:F_RMISS] != '0));

  // R5
  align_nolookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && f_align |-> !lk_en);

  // R9
  miss_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en && !lk_hit |=> rsp_tag_wr && !rsp_ok);

  // R4
  bypass_nolookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && byp_now |=> rsp_ok && !rsp_uncache && !rsp_tag_wr);

endmodule

// File: tb/tb_dtc_top.sv
module tb_dtc_top;
  localparam int PA_W = 40;
  localparam logic [63:0] HLO = 64'h0000_8000_0000_0000;
  localparam logic [63:0] HHI = 64'hFFFF_7FFF_FFFF_FFFF;
  localparam int NE = 6;

  typedef struct {
    logic ok; logic [PA_W-1:0] pa; logic unc; logic [7:0] fault;
    logic tag_wr; logic [63:0] tag; string lbl;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [63:0] req_state = 0, req_va = 0;
  logic [1:0] req_size = 0, req_ctxsel = 0;
  logic req_write = 0, req_implicit = 0, req_real = 0, req_nofault = 0;
  logic lk_en, lk_real;
  logic [63:0] lk_va;
  logic [15:0] lk_ctx;
  logic [7:0] lk_part;
  logic lk_hit, lk_priv, lk_writable, lk_nofault, lk_sideeff;
  logic [PA_W-1:0] lk_pa;
  logic [5:0] lk_shift;
  logic rsp_valid, rsp_ready = 1, rsp_ok, rsp_uncache, rsp_tag_wr;
  logic [PA_W-1:0] rsp_pa;
  logic [7:0] rsp_fault;
  logic [63:0] rsp_tag;

  int checks = 0, fails = 0;
  bit rdy_random = 0;
  string cur_lbl = "R3";
  exp_t q[$];

  logic [63:0] t_base [NE];
  logic [15:0] t_ctx [NE];
  logic [7:0]  t_part [NE];
  logic        t_real [NE];
  logic [5:0]  t_shift [NE];
  logic [PA_W-1:0] t_pa [NE];
  logic t_priv [NE], t_wr [NE], t_nf [NE], t_se [NE];

  always #4 clk = ~clk;

  dtc_top #(.PA_W(PA_W), .HOLE_LO(HLO), .HOLE_HI(HHI)) dut (.*);

  function automatic int tfind(logic [63:0] va, logic [15:0] ctx,
                               logic [7:0] part, logic rl);
    for (int i = 0; i < NE; i++)
      if ((va >> t_shift[i]) == (t_base[i] >> t_shift[i]) && part == t_part[i]
          && rl == t_real[i] && (rl || ctx == t_ctx[i]))
        return i;
    return -1;
  endfunction

  always_comb begin
    int k;
    k = tfind(lk_va, lk_ctx, lk_part, lk_real);
    lk_hit = (k >= 0);
    lk_pa = '0; lk_shift = '0; lk_priv = 0; lk_writable = 0; lk_nofault = 0; lk_sideeff = 0;
    if (k >= 0) begin
      lk_pa = t_pa[k]; lk_shift = t_shift[k]; lk_priv = t_priv[k];
      lk_writable = t_wr[k]; lk_nofault = t_nf[k]; lk_sideeff = t_se[k];
    end
  end

  function automatic exp_t model(logic [63:0] s, logic [63:0] va, logic [1:0] sz,
      logic wr, logic imp, logic rq, logic nf, logic [1:0] cs, string lbl);
    exp_t e;
    logic hp, rd, pv, am, en, rl;
    logic [7:0] part; logic [2:0] tl; logic [15:0] pri, sec, ctx;
    logic [63:0] v, m;
    int k;
    e.ok = 0; e.pa = 0; e.unc = 0; e.fault = 0; e.tag_wr = 0; e.tag = 0; e.lbl = lbl;
    hp = s[0]; rd = s[1]; pv = s[2]; am = s[3]; en = s[5];
    part = s[15:8]; tl = s[18:16]; pri = s[47:32]; sec = s[63:48];
    if (hp && imp) begin e.ok = 1; e.pa = va[PA_W-1:0]; return e; end
    if ((va % (64'd1 << sz)) != 0) begin e.fault = 8'h01; return e; end
    v = am ? (va & 64'hFFFF_FFFF) : va;
    if (v >= HLO && v <= HHI) begin e.fault = 8'h02; return e; end
    if (hp && !rq) begin e.ok = 1; e.pa = v[PA_W-1:0]; return e; end
    rl = (!en && !hp && !rd) || rq;
    if (imp) ctx = (tl == 0) ? pri : 16'h0;
    else ctx = (cs == 0) ? pri : (cs == 1) ? sec : 16'h0;
    k = tfind(v, ctx, part, rl);
    e.tag = {v[63:13], ctx[12:0]};
    e.tag_wr = 1;
    if (k < 0) e.fault = rl ? 8'h04 : 8'h08;
    else if (t_priv[k] && !pv) e.fault = 8'h10;
    else if (wr && !t_wr[k]) e.fault = 8'h20;
    else if (t_nf[k] && !nf) e.fault = 8'h40;
    else if (t_se[k] && nf) e.fault = 8'h80;
    else begin
      e.tag_wr = 0; e.tag = 0; e.ok = 1; e.unc = t_se[k];
      m = (64'd1 << t_shift[k]) - 1;
      e.pa = (t_pa[k] & ~m[PA_W-1:0]) | (v[PA_W-1:0] & m[PA_W-1:0]);
    end
    return e;
  endfunction

  task automatic chk(bit cond, string req, string what);
    checks++;
    if (!cond) begin fails++; $display("FAIL %s: %s", req, what); end
  endtask

  // monitor: samples 2 time units after the falling edge
  bit held = 0;
  logic [PA_W-1:0] h_pa; logic [7:0] h_fault; logic [63:0] h_tag; logic h_ok;
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        if (held) begin
          // R2 response held while stalled
          chk(rsp_valid && rsp_pa == h_pa && rsp_fault == h_fault && rsp_tag == h_tag
              && rsp_ok == h_ok, "R2",
              $sformatf("hold: act v=%0b f=%h pa=%h exp f=%h pa=%h",
                        rsp_valid, rsp_fault, rsp_pa, h_fault, h_pa));
        end
        held = rsp_valid && !rsp_ready;
        h_pa = rsp_pa; h_fault = rsp_fault; h_tag = rsp_tag; h_ok = rsp_ok;
        if (rsp_valid && rsp_ready) begin
          if (q.size() == 0) chk(0, "R2", "response with no request pending: act 1 exp 0");
          else begin
            exp_t e;
            e = q.pop_front();
            chk(rsp_ok == e.ok && rsp_pa == e.pa && rsp_uncache == e.unc
                && rsp_fault == e.fault && rsp_tag_wr == e.tag_wr && rsp_tag == e.tag,
                e.lbl, $sformatf("act ok=%0b pa=%h unc=%0b f=%h tw=%0b tag=%h exp ok=%0b pa=%h unc=%0b f=%h tw=%0b tag=%h",
                  rsp_ok, rsp_pa, rsp_uncache, rsp_fault, rsp_tag_wr, rsp_tag,
                  e.ok, e.pa, e.unc, e.fault, e.tag_wr, e.tag));
            // R12 exactly one outcome
            chk($countones({rsp_ok, rsp_fault}) == 1, "R12",
                $sformatf("outcome bits act %0d exp 1", $countones({rsp_ok, rsp_fault})));
          end
        end
        if (req_valid) begin
          // R2 ready rule
          chk(req_ready == (!rsp_valid || rsp_ready), "R2",
              $sformatf("req_ready act %0b exp %0b", req_ready, !rsp_valid || rsp_ready));
        end
        if (req_valid && req_ready)
          q.push_back(model(req_state, req_va, req_size, req_write, req_implicit,
                            req_real, req_nofault, req_ctxsel, cur_lbl));
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      rsp_ready = rdy_random ? (($urandom % 4) != 0) : 1'b1;
    end
  end

  task automatic issue(logic [63:0] s, logic [63:0] va, logic [1:0] sz, logic wr,
                       logic imp, logic rq, logic nf, logic [1:0] cs, string lbl);
    req_state = s; req_va = va; req_size = sz; req_write = wr; req_implicit = imp;
    req_real = rq; req_nofault = nf; req_ctxsel = cs; cur_lbl = lbl; req_valid = 1;
    forever begin
      #3;
      if (req_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
  endtask

  function automatic logic [63:0] mk_state(logic [15:0] sec, logic [15:0] pri,
      logic [2:0] tl, logic [7:0] part, logic en, logic am, logic pv, logic rd, logic hp);
    return {sec, pri, 13'h0, tl, part, 2'b00, en, 1'b0, am, pv, rd, hp};
  endfunction

  initial begin : wd
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: act timeout exp completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] s;
    void'($urandom(32'd20240611));
    t_base[0]=64'h0000_0000_4000_0000; t_ctx[0]=16'h0011; t_real[0]=0; t_shift[0]=13;
    t_pa[0]=40'h00_1234_6000; t_priv[0]=0; t_wr[0]=1; t_nf[0]=0; t_se[0]=0;
    t_base[1]=64'h0000_0001_0000_0000; t_ctx[1]=16'h0011; t_real[1]=0; t_shift[1]=16;
    t_pa[1]=40'h00_5555_0000; t_priv[1]=1; t_wr[1]=1; t_nf[1]=0; t_se[1]=0;
    t_base[2]=64'h0000_0000_2000_0000; t_ctx[2]=16'h0022; t_real[2]=0; t_shift[2]=22;
    t_pa[2]=40'h0F_AB40_0000; t_priv[2]=0; t_wr[2]=0; t_nf[2]=0; t_se[2]=1;
    t_base[3]=64'h0000_0000_0800_0000; t_ctx[3]=16'h0000; t_real[3]=1; t_shift[3]=19;
    t_pa[3]=40'h00_7788_0000; t_priv[3]=0; t_wr[3]=1; t_nf[3]=1; t_se[3]=0;
    t_base[4]=64'h0000_0000_0100_0000; t_ctx[4]=16'h0000; t_real[4]=0; t_shift[4]=13;
    t_pa[4]=40'h00_0042_2000; t_priv[4]=0; t_wr[4]=1; t_nf[4]=0; t_se[4]=0;
    t_base[5]=64'hFFFF_FFFF_F000_0000; t_ctx[5]=16'h0011; t_real[5]=0; t_shift[5]=13;
    t_pa[5]=40'h00_9900_0000; t_priv[5]=0; t_wr[5]=1; t_nf[5]=0; t_se[5]=0;
    for (int i = 0; i < NE; i++) t_part[i] = 8'h05;

    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    chk(rsp_valid == 0, "R1", $sformatf("rsp_valid act %0b exp 0", rsp_valid));
    chk(req_ready == 1, "R1", $sformatf("req_ready act %0b exp 1", req_ready));
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    s = mk_state(16'h0022, 16'h0011, 0, 8'h05, 1, 0, 0, 0, 0);
    issue(mk_state(16'h0022,16'h0011,0,8'h05,1,0,0,0,1), 64'h0000_9000_0000_1235,
          3, 1, 1, 0, 0, 0, "R4");
    issue(s, 64'h0000_0000_4000_0004, 3, 0, 0, 0, 0, 0, "R5");
    issue(s, 64'h0000_9000_0000_0000, 0, 0, 0, 0, 0, 0, "R6");
    issue(mk_state(16'h0022,16'h0011,0,8'h05,1,1,0,0,0), 64'hFFFF_FFFF_F000_0040,
          2, 0, 0, 0, 0, 0, "R6");
    issue(s, 64'hFFFF_FFFF_F000_0040, 2, 0, 0, 0, 0, 0, "R3");
    issue(s, 64'h0000_0000_4000_1238, 3, 1, 0, 0, 0, 0, "R11");
    issue(s, 64'h0000_0001_0000_0100, 2, 1, 0, 0, 0, 0, "R10");
    issue(mk_state(16'h0022,16'h0011,0,8'h05,1,0,1,0,0), 64'h0000_0001_0000_0100,
          2, 0, 0, 0, 0, 0, "R11");
    issue(s, 64'h0000_0000_2012_3450, 2, 1, 0, 0, 0, 1, "R10");
    issue(s, 64'h0000_0000_2012_3450, 2, 0, 0, 0, 1, 1, "R10");
    issue(s, 64'h0000_0000_2012_3450, 2, 0, 0, 0, 0, 1, "R8");
    issue(s, 64'h0000_0000_0801_0000, 3, 0, 0, 1, 0, 0, "R10");
    issue(s, 64'h0000_0000_0801_0000, 3, 0, 0, 1, 1, 0, "R8");
    issue(mk_state(16'h0022,16'h0011,0,8'h05,0,0,0,0,0), 64'h0000_0000_0801_0008,
          3, 1, 0, 0, 1, 0, "R8");
    issue(mk_state(16'h0022,16'h0011,1,8'h05,1,0,0,0,0), 64'h0000_0000_0100_0010,
          2, 1, 1, 0, 0, 0, "R8");
    issue(mk_state(16'h0022,16'h0011,0,8'h05,1,0,0,0,1), 64'h0000_0123_4567_8000,
          2, 0, 0, 0, 0, 0, "R7");
    issue(s, 64'h0000_0000_0900_0000, 3, 0, 0, 1, 0, 0, "R9");
    issue(s, 64'h0000_0000_7000_0000, 3, 0, 0, 0, 0, 2, "R9");

    rdy_random = 1;
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] va, msk; logic [1:0] sz; int r, k;
      s = mk_state(($urandom%2) ? 16'h0022 : 16'h0011, ($urandom%2) ? 16'h0011 : 16'h0022,
                   ($urandom%3 == 0) ? 3'($urandom%8) : 3'd0,
                   ($urandom%8 == 0) ? 8'h07 : 8'h05,
                   ($urandom%8) != 0, ($urandom%8) == 0, ($urandom%2) == 1,
                   ($urandom%8) == 0, ($urandom%6) == 0);
      sz = 2'($urandom % 4);
      r = $urandom % 10;
      if (r == 0) va = HLO + ({32'h0, $urandom} << 16);
      else if (r == 1) va = {$urandom, $urandom};
      else begin
        k = $urandom % NE;
        msk = (64'd1 << t_shift[k]) - 1;
        va = t_base[k] + ({$urandom, $urandom} & msk);
      end
      if (($urandom % 4) != 0) va = va & ~((64'd1 << sz) - 1);
      issue(s, va, sz, $urandom%2, ($urandom%4) == 0, ($urandom%8) == 0,
            ($urandom%6) == 0, 2'($urandom%4), "R10");
    end
    req_valid = 0;
    rdy_random = 0;
    repeat (6) @(negedge clk);
    // R2 every accepted request answered
    chk(q.size() == 0, "R2", $sformatf("pending act %0d exp 0", q.size()));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule